// File: doc/BRIEF.md
# Link Rate Reconfiguration Sequencer

This block walks one serial Ethernet channel from the rate it runs at to a newly requested rate. A request names one of seven destination modes, covering 1G, 10G and 25G, with or without forward error correction and with or without timestamping. The block first holds the channel in reset. It then works through a fixed list of transceiver attribute commands and configuration register writes, one at a time, each over a request/acknowledge port. After that it releases the channel and waits for the link status flags in two phases. Between the two phases it clears the statistics counters and starts the traffic generator.

The per-mode register contents come from a small computed lookup. Each ready wait is guarded by a cycle limit supplied at a port. If the limit runs out, the block parks in a sticky error state, and a new request clears it. On success the block pulses a completion flag and reports the mode now active. A request for the mode already active runs the whole sequence again.

Top module: `rate_reconfig_seq`

## Requirements
- R1: After reset the channel resets are released (high), both command requests are low, the clear, generator, done and error outputs are low, and the reported rate is 0.
- R2: A request is taken only in the idle or error state, and only with a rate code from 0 to 6 (0=1G, 1=10G, 2=10G with timestamping, 3=25G, 4=25G with FEC, 5=25G with timestamping, 6=25G with timestamping and FEC). Both channel resets are driven low on the clock edge that samples the request. Code 7 is ignored.
- R3: While the resets are low, exactly ten commands are issued in this order: attribute 0x0001 value 0 (lane off); register 0x01 value 1 (analog reset); register 0x02 TX ratio; register 0x03 RX ratio; registers 0x10, 0x11, 0x12; attribute 0x000E value 0 (recovered-clock phase); attribute 0x0001 value 1 (lane on); attribute 0x0008 value 1 (serial loopback).
- R4: The ratio is 8 for 1G, 66 for 10G and 165 for 25G. Register 0x10 carries the rate code. Register 0x11 carries 1 for codes 4 and 6 and 0 otherwise. Register 0x12 carries the ratio.
- R5: A command request holds its selector and data stable until it is acknowledged. The attribute and register requests are never high together. Both requests are low in the cycle after an acknowledge.
- R6: Both resets are released together, only after the loopback command has been acknowledged.
- R7: The first ready wait needs status bits [4:0] all set for 10G/25G destinations, and bits [2:0] all set for 1G. Any other status pattern keeps the block waiting.
- R8: Once the first wait is met, the statistics clear is a one-cycle pulse, and the generator enable goes high in the following cycle.
- R9: For 10G/25G destinations the block then waits for status bits [5:0] all set. For 1G it completes right after the generator starts, whatever bit 5 holds.
- R10: Completion gives a one-cycle done pulse, and from then on the reported rate equals the destination code.
- R11: If a ready wait lasts the number of cycles given at the timeout input, the error flag rises. It stays high until a valid request is accepted, and the accept clears it.
- R12: Requesting the rate already active replays the full command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Reconfiguration request, sampled on the clock edge |
| rate_i | input | 3 | Destination rate code |
| timeout_i | input | TO_W | Cycle limit for each ready wait |
| tx_rst_n_o | output | 1 | Active-low TX channel reset |
| rx_rst_n_o | output | 1 | Active-low RX channel reset |
| attr_req_o | output | 1 | Transceiver attribute command request |
| attr_ack_i | input | 1 | Attribute command acknowledge |
| cfg_req_o | output | 1 | Configuration register write request |
| cfg_ack_i | input | 1 | Register write acknowledge |
| cmd_sel_o | output | CMD_W | Attribute code or register address |
| cmd_data_o | output | DATA_W | Attribute value or register data |
| stat_i | input | 6 | Ready/status flags |
| stat_clr_o | output | 1 | Statistics clear pulse |
| gen_en_o | output | 1 | Traffic generator enable |
| done_o | output | 1 | Completion pulse |
| cur_rate_o | output | 3 | Rate code now active |
| err_o | output | 1 | Sticky timeout error |

## Verification
A wrong state or step counter shows up at the command port right away. A skipped, repeated or reordered step changes the selector or data of the next handshake, so the mismatch appears within one command. A wrong wait mask shows as a statistics clear, or a done pulse, during a status pattern that should hold the block, and it appears within a cycle of that pattern being applied. A broken timeout counter shows as an error flag that is early, late or missing, measured against the programmed limit. A done pulse or rate register that misbehaves shows at the end of every sequence.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int RATE_W = 3;
  localparam int STAT_W = 6;
  localparam int NCFG   = 3;

  localparam int unsigned ATTR_LANE  = 1;
  localparam int unsigned ATTR_PHASE = 14;
  localparam int unsigned ATTR_LOOP  = 8;
  localparam int unsigned ADDR_ARST  = 1;
  localparam int unsigned ADDR_TXR   = 2;
  localparam int unsigned ADDR_RXR   = 3;
  localparam int unsigned ADDR_CFG   = 16;

  localparam logic [STAT_W-1:0] READY_ALL = 6'h3F;

  // Command steps first, in issue order; the FSM advances by increment.
  typedef enum logic [3:0] {
    ST_IDLE, ST_DIS, ST_ARST, ST_TXR, ST_RXR, ST_CFG, ST_PHS, ST_EN,
    ST_LPB, ST_REL, ST_WAIT1, ST_CLR, ST_WAIT2, ST_DONE, ST_ERR
  } seq_st_e;

  function automatic logic rate_ok(input logic [RATE_W-1:0] r);
    return r <= 3'd6;
  endfunction

  function automatic logic rate_1g(input logic [RATE_W-1:0] r);
    return r == 3'd0;
  endfunction

  function automatic logic rate_fec(input logic [RATE_W-1:0] r);
    return (r == 3'd4) || (r == 3'd6);
  endfunction

  function automatic logic [7:0] rate_ratio(input logic [RATE_W-1:0] r);
    if (r == 3'd0)      return 8'd8;
    else if (r <= 3'd2) return 8'd66;
    else                return 8'd165;
  endfunction

  function automatic logic [STAT_W-1:0] ready_mask1(input logic [RATE_W-1:0] r);
    return rate_1g(r) ? 6'h07 : 6'h1F;
  endfunction
endpackage

// File: rtl/rrs_step_table.sv
module rrs_step_table
  import rrs_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  seq_st_e           step_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              is_cfg_o,
  output logic [CMD_W-1:0]  sel_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] ratio_w;
  logic [DATA_W-1:0] table_w;

  assign ratio_w = DATA_W'(rate_ratio(rate_i));

  always_comb begin
    case (idx_i)
      IDX_W'(0): table_w = DATA_W'(rate_i);
      IDX_W'(1): table_w = DATA_W'(rate_fec(rate_i));
      default:   table_w = ratio_w;
    endcase
  end

  always_comb begin
    is_cfg_o = 1'b0;
    sel_o    = '0;
    data_o   = '0;
    case (step_i)
      ST_DIS:  begin sel_o = CMD_W'(ATTR_LANE); end
      ST_ARST: begin is_cfg_o = 1'b1; sel_o = CMD_W'(ADDR_ARST); data_o = DATA_W'(1); end
      ST_TXR:  begin is_cfg_o = 1'b1; sel_o = CMD_W'(ADDR_TXR); data_o = ratio_w; end
      ST_RXR:  begin is_cfg_o = 1'b1; sel_o = CMD_W'(ADDR_RXR); data_o = ratio_w; end
      ST_CFG:  begin
        is_cfg_o = 1'b1;
        sel_o    = CMD_W'(ADDR_CFG) + CMD_W'(idx_i);
        data_o   = table_w;
      end
      ST_PHS:  begin sel_o = CMD_W'(ATTR_PHASE); end
      ST_EN:   begin sel_o = CMD_W'(ATTR_LANE); data_o = DATA_W'(1); end
      ST_LPB:  begin sel_o = CMD_W'(ATTR_LOOP); data_o = DATA_W'(1); end
      default: begin sel_o = '0; end
    endcase
  end
endmodule

// File: rtl/rrs_cmd_port.sv
module rrs_cmd_port #(
  parameter int CMD_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              is_cfg_i,
  input  logic [CMD_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              attr_ack_i,
  input  logic              cfg_ack_i,
  output logic              attr_req_o,
  output logic              cfg_req_o,
  output logic [CMD_W-1:0]  sel_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  logic              pend_q, kind_q, done_q;
  logic [CMD_W-1:0]  sel_q;
  logic [DATA_W-1:0] data_q;
  logic              ack_w, launch_w;

  assign ack_w    = kind_q ? cfg_ack_i : attr_ack_i;
  assign launch_w = go_i & ~pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= pend_q & ack_w;
      if (launch_w) begin
        pend_q <= 1'b1;
        kind_q <= is_cfg_i;
      end else if (pend_q & ack_w) begin
        pend_q <= 1'b0;
      end
    end
  end

  // Payload registers: datapath, loaded only on launch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      data_q <= '0;
    end else if (launch_w) begin
      sel_q  <= sel_i;
      data_q <= data_i;
    end
  end

  assign attr_req_o = pend_q & ~kind_q;
  assign cfg_req_o  = pend_q & kind_q;
  assign sel_o      = sel_q;
  assign data_o     = data_q;
  assign done_o     = done_q;
endmodule

// File: rtl/rrs_ready_watch.sv
module rrs_ready_watch #(
  parameter int STAT_W = 6,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              run_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic [TO_W-1:0]   limit_i,
  output logic              met_o,
  output logic              expired_o
);
  logic [TO_W-1:0] cnt_q;
  logic            cnt_en;

  assign met_o     = (stat_i & mask_i) == mask_i;
  assign expired_o = run_i & ~met_o & (cnt_q >= limit_i);
  assign cnt_en    = run_i & ~met_o & ~expired_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (arm_i)  cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + TO_W'(1);
  end
endmodule

// File: rtl/rate_reconfig_seq.sv
module rate_reconfig_seq
  import rrs_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int DATA_W = 32,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [2:0]        rate_i,
  input  logic [TO_W-1:0]   timeout_i,
  output logic              tx_rst_n_o,
  output logic              rx_rst_n_o,
  output logic              attr_req_o,
  input  logic              attr_ack_i,
  output logic              cfg_req_o,
  input  logic              cfg_ack_i,
  output logic [CMD_W-1:0]  cmd_sel_o,
  output logic [DATA_W-1:0] cmd_data_o,
  input  logic [5:0]        stat_i,
  output logic              stat_clr_o,
  output logic              gen_en_o,
  output logic              done_o,
  output logic [2:0]        cur_rate_o,
  output logic              err_o
);
  localparam int IDX_W = (NCFG > 1) ? $clog2(NCFG) : 1;

  seq_st_e           state_q, state_d;
  logic              issued_q, issued_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              chrst_q, chrst_d;
  logic              gen_q, gen_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic [RATE_W-1:0] cur_q, cur_d;
  logic [RATE_W-1:0] dst_q, dst_d;

  logic              go_w, cmd_done_w, accept_w;
  logic              tbl_cfg_w;
  logic [CMD_W-1:0]  tbl_sel_w;
  logic [DATA_W-1:0] tbl_data_w;
  logic              met_w, expired_w, arm_w, run_w;
  logic [STAT_W-1:0] mask_w;

  rrs_step_table #(.CMD_W(CMD_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_table (
    .step_i(state_q), .idx_i(idx_q), .rate_i(dst_q),
    .is_cfg_o(tbl_cfg_w), .sel_o(tbl_sel_w), .data_o(tbl_data_w)
  );

  rrs_cmd_port #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .go_i(go_w), .is_cfg_i(tbl_cfg_w),
    .sel_i(tbl_sel_w), .data_i(tbl_data_w),
    .attr_ack_i(attr_ack_i), .cfg_ack_i(cfg_ack_i),
    .attr_req_o(attr_req_o), .cfg_req_o(cfg_req_o),
    .sel_o(cmd_sel_o), .data_o(cmd_data_o), .done_o(cmd_done_w)
  );

  assign arm_w  = (state_q == ST_REL) || (state_q == ST_CLR);
  assign run_w  = (state_q == ST_WAIT1) || (state_q == ST_WAIT2);
  assign mask_w = (state_q == ST_WAIT1) ? ready_mask1(dst_q) : READY_ALL;

  rrs_ready_watch #(.STAT_W(STAT_W), .TO_W(TO_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_w), .run_i(run_w),
    .stat_i(stat_i), .mask_i(mask_w), .limit_i(timeout_i),
    .met_o(met_w), .expired_o(expired_w)
  );

  assign accept_w = req_i && rate_ok(rate_i) &&
                    ((state_q == ST_IDLE) || (state_q == ST_ERR));

  always_comb begin
    state_d  = state_q;
    issued_d = issued_q;
    idx_d    = idx_q;
    chrst_d  = chrst_q;
    gen_d    = gen_q;
    err_d    = err_q;
    done_d   = 1'b0;
    cur_d    = cur_q;
    dst_d    = dst_q;
    go_w     = 1'b0;
    case (state_q)
      ST_IDLE, ST_ERR: begin
        if (accept_w) begin
          state_d  = ST_DIS;
          dst_d    = rate_i;
          chrst_d  = 1'b0;
          gen_d    = 1'b0;
          err_d    = 1'b0;
          issued_d = 1'b0;
          idx_d    = '0;
        end
      end
      ST_DIS, ST_ARST, ST_TXR, ST_RXR, ST_CFG, ST_PHS, ST_EN, ST_LPB: begin
        if (!issued_q) begin
          go_w     = 1'b1;
          issued_d = 1'b1;
        end else if (cmd_done_w) begin
          issued_d = 1'b0;
          if ((state_q == ST_CFG) && (idx_q != IDX_W'(NCFG - 1)))
            idx_d = idx_q + IDX_W'(1);
          else
            state_d = seq_st_e'(state_q + 4'd1);
        end
      end
      ST_REL: begin
        chrst_d = 1'b1;
        state_d = ST_WAIT1;
      end
      ST_WAIT1: begin
        if (met_w) state_d = ST_CLR;
        else if (expired_w) begin
          state_d = ST_ERR;
          err_d   = 1'b1;
        end
      end
      ST_CLR: begin
        gen_d   = 1'b1;
        state_d = rate_1g(dst_q) ? ST_DONE : ST_WAIT2;
      end
      ST_WAIT2: begin
        if (met_w) state_d = ST_DONE;
        else if (expired_w) begin
          state_d = ST_ERR;
          err_d   = 1'b1;
        end
      end
      ST_DONE: begin
        done_d  = 1'b1;
        cur_d   = dst_q;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      idx_q    <= '0;
      chrst_q  <= 1'b1;
      gen_q    <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      cur_q    <= '0;
      dst_q    <= '0;
    end else begin
      state_q  <= state_d;
      issued_q <= issued_d;
      idx_q    <= idx_d;
      chrst_q  <= chrst_d;
      gen_q    <= gen_d;
      err_q    <= err_d;
      done_q   <= done_d;
      cur_q    <= cur_d;
      dst_q    <= dst_d;
    end
  end

  assign tx_rst_n_o = chrst_q;
  assign rx_rst_n_o = chrst_q;
  assign stat_clr_o = (state_q == ST_CLR);
  assign gen_en_o   = gen_q;
  assign done_o     = done_q;
  assign cur_rate_o = cur_q;
  assign err_o      = err_q;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int CMD_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              tx_rst_n_o,
  input logic              rx_rst_n_o,
  input logic              attr_req_o,
  input logic              attr_ack_i,
  input logic              cfg_req_o,
  input logic              cfg_ack_i,
  input logic [CMD_W-1:0]  cmd_sel_o,
  input logic [DATA_W-1:0] cmd_data_o,
  input logic              stat_clr_o,
  input logic              gen_en_o,
  input logic              done_o,
  input logic              err_o
);
  a_r3_cmd_under_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_req_o || cfg_req_o) |-> (!tx_rst_n_o && !rx_rst_n_o));

  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(attr_req_o && cfg_req_o));

  a_r5_attr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_req_o && !attr_ack_i) |=>
      (attr_req_o && $stable(cmd_sel_o) && $stable(cmd_data_o)));

  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_o && !cfg_ack_i) |=>
      (cfg_req_o && $stable(cmd_sel_o) && $stable(cmd_data_o)));

  a_r5_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((attr_req_o && attr_ack_i) || (cfg_req_o && cfg_ack_i)) |=>
      (!attr_req_o && !cfg_req_o));

  a_r6_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_n_o == rx_rst_n_o);

  a_r8_clr_then_gen: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr_o |=> (!stat_clr_o && gen_en_o));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r10_done_running: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (tx_rst_n_o && gen_en_o && !err_o));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !req_i) |=> err_o);
endmodule

bind rate_reconfig_seq rrs_checker #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i),
  .tx_rst_n_o(tx_rst_n_o), .rx_rst_n_o(rx_rst_n_o),
  .attr_req_o(attr_req_o), .attr_ack_i(attr_ack_i),
  .cfg_req_o(cfg_req_o), .cfg_ack_i(cfg_ack_i),
  .cmd_sel_o(cmd_sel_o), .cmd_data_o(cmd_data_o),
  .stat_clr_o(stat_clr_o), .gen_en_o(gen_en_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/rate_reconfig_seq_tb.sv
module rate_reconfig_seq_tb;
  localparam int CMD_W  = 16;
  localparam int DATA_W = 32;
  localparam int TO_W   = 16;
  localparam int NVEC   = 9;
  // {rate code, partial status that must not satisfy the first wait}
  localparam logic [8:0] VEC [NVEC] = '{
    {3'd4, 6'h17}, {3'd4, 6'h0F}, {3'd3, 6'h1E}, {3'd0, 6'h03}, {3'd1, 6'h1B},
    {3'd0, 6'h05}, {3'd2, 6'h1D}, {3'd5, 6'h3E}, {3'd6, 6'h1C}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req;
  logic [2:0]        rate;
  logic [TO_W-1:0]   tmo;
  logic              tx_rst_n_o, rx_rst_n_o, attr_req_o, cfg_req_o;
  logic              attr_ack, cfg_ack;
  logic [CMD_W-1:0]  cmd_sel_o;
  logic [DATA_W-1:0] cmd_data_o;
  logic [5:0]        stat;
  logic              stat_clr_o, gen_en_o, done_o, err_o;
  logic [2:0]        cur_rate_o;

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  int clr_cnt = 0;
  int log_n = 0;
  logic              log_cfg  [16];
  logic [CMD_W-1:0]  log_sel  [16];
  logic [DATA_W-1:0] log_data [16];

  always #4 clk = ~clk;

  rate_reconfig_seq #(.CMD_W(CMD_W), .DATA_W(DATA_W), .TO_W(TO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rate_i(rate), .timeout_i(tmo),
    .tx_rst_n_o(tx_rst_n_o), .rx_rst_n_o(rx_rst_n_o),
    .attr_req_o(attr_req_o), .attr_ack_i(attr_ack),
    .cfg_req_o(cfg_req_o), .cfg_ack_i(cfg_ack),
    .cmd_sel_o(cmd_sel_o), .cmd_data_o(cmd_data_o), .stat_i(stat),
    .stat_clr_o(stat_clr_o), .gen_en_o(gen_en_o), .done_o(done_o),
    .cur_rate_o(cur_rate_o), .err_o(err_o)
  );

  // Responder: acknowledge one cycle after a request is seen.
  always @(negedge clk) begin
    attr_ack <= attr_req_o & ~attr_ack;
    cfg_ack  <= cfg_req_o & ~cfg_ack;
  end

  // Monitors sample pre-edge values at the rising edge.
  always @(posedge clk) begin
    if (rst_n) begin
      if (done_o) done_cnt++;
      if (stat_clr_o) clr_cnt++;
      if ((attr_req_o && attr_ack) || (cfg_req_o && cfg_ack)) begin
        if (log_n < 16) begin
          log_cfg[log_n]  = cfg_req_o;
          log_sel[log_n]  = cmd_sel_o;
          log_data[log_n] = cmd_data_o;
        end
        log_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ratio(input logic [2:0] r);
    return (r == 3'd0) ? 32'd8 : ((r <= 3'd2) ? 32'd66 : 32'd165);
  endfunction

  // Expected command i: {is_cfg, selector, data} per R3 and R4.
  function automatic logic [48:0] exp_cmd(input int i, input logic [2:0] r);
    logic [31:0] fec;
    fec = ((r == 3'd4) || (r == 3'd6)) ? 32'd1 : 32'd0;
    case (i)
      0: return {1'b0, 16'h0001, 32'd0};
      1: return {1'b1, 16'h0001, 32'd1};
      2: return {1'b1, 16'h0002, exp_ratio(r)};
      3: return {1'b1, 16'h0003, exp_ratio(r)};
      4: return {1'b1, 16'h0010, 29'd0, r};
      5: return {1'b1, 16'h0011, fec};
      6: return {1'b1, 16'h0012, exp_ratio(r)};
      7: return {1'b0, 16'h000E, 32'd0};
      8: return {1'b0, 16'h0001, 32'd1};
      default: return {1'b0, 16'h0008, 32'd1};
    endcase
  endfunction

  task automatic pulse_req(input logic [2:0] r);
    @(negedge clk);
    req = 1'b1; rate = r;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic run_seq(input logic [2:0] r, input logic [5:0] part1);
    int c0, d0;
    stat = '0;
    log_n = 0;
    c0 = clr_cnt;
    pulse_req(r);
    d0 = done_cnt;
    chk(!tx_rst_n_o && !rx_rst_n_o && !gen_en_o && !attr_req_o && !cfg_req_o,
        "R2 resets low one edge after request", {tx_rst_n_o, rx_rst_n_o, gen_en_o}, 0);
    for (int k = 0; k < 400 && !tx_rst_n_o; k++) @(negedge clk);
    chk(tx_rst_n_o && rx_rst_n_o, "R6 resets released", {rx_rst_n_o, tx_rst_n_o}, 3);
    chk(log_n == 10, "R6 R12 ten commands before release", log_n, 10);
    for (int i = 0; i < 10; i++)
      chk({log_cfg[i], log_sel[i], log_data[i]} == exp_cmd(i, r),
          $sformatf("R3 R4 command %0d rate %0d", i, r),
          {log_cfg[i], log_sel[i][14:0], log_data[i][15:0]},
          {exp_cmd(i, r)[48], exp_cmd(i, r)[46:32], exp_cmd(i, r)[15:0]});
    stat = part1;
    repeat (12) @(negedge clk);
    chk(clr_cnt == c0 && !gen_en_o, "R7 partial status holds first wait", {part1, gen_en_o}, {part1, 1'b0});
    stat = (r == 3'd0) ? 6'h07 : 6'h1F;
    for (int k = 0; k < 20 && !stat_clr_o; k++) @(negedge clk);
    chk(stat_clr_o && !gen_en_o, "R8 clear pulse before generator", {stat_clr_o, gen_en_o}, 2'b10);
    @(negedge clk);
    chk(gen_en_o && !stat_clr_o, "R8 generator after one-cycle clear", {stat_clr_o, gen_en_o}, 2'b01);
    if (r != 3'd0) begin
      repeat (10) @(negedge clk);
      chk(done_cnt == d0, "R9 second wait needs bit 5", done_cnt - d0, 0);
      stat = 6'h3F;
    end
    for (int k = 0; k < 40 && done_cnt == d0; k++) @(negedge clk);
    @(negedge clk);
    chk(done_cnt == d0 + 1, "R9 R10 exactly one done pulse", done_cnt - d0, 1);
    chk(cur_rate_o == r, "R10 reported rate", cur_rate_o, r);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; rate = '0; tmo = 16'd1000; stat = '0;
    attr_ack = 1'b0; cfg_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_rst_n_o && rx_rst_n_o && !attr_req_o && !cfg_req_o && !stat_clr_o &&
        !gen_en_o && !done_o && !err_o && cur_rate_o == 3'd0,
        "R1 reset state", {tx_rst_n_o, attr_req_o, cfg_req_o, gen_en_o, done_o, err_o, cur_rate_o}, 9'h100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: undefined code 7 is ignored
    log_n = 0;
    pulse_req(3'd7);
    repeat (6) @(negedge clk);
    chk(tx_rst_n_o && log_n == 0, "R2 code 7 ignored", {log_n[7:0], tx_rst_n_o}, 9'h001);

    // Vector table; entries 0 and 1 request the same rate twice (R12).
    for (int v = 0; v < NVEC; v++) run_seq(VEC[v][8:6], VEC[v][5:0]);

    // R11: timeout in the first wait
    tmo = 16'd40;
    stat = '0;
    pulse_req(3'd3);
    for (int k = 0; k < 400 && !tx_rst_n_o; k++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(!err_o, "R11 no error before limit", err_o, 0);
    repeat (40) @(negedge clk);
    chk(err_o, "R11 error after limit", err_o, 1);
    pulse_req(3'd7);
    repeat (10) @(negedge clk);
    chk(err_o && tx_rst_n_o, "R11 error sticky over invalid request", {err_o, tx_rst_n_o}, 2'b11);
    tmo = 16'd1000;
    run_seq(3'd0, 6'h06);
    chk(!err_o, "R11 error cleared by new request", err_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule